// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up a bank of 24 digital input lines before software samples them or before they feed an edge detector. Each raw line first passes through a two-flop synchroniser. Every line has its own enable bit. When the enable is off, the synchronised level goes straight through. When it is on, the line's output moves to a new level only after that level has held for a programmable stability time. All lines share one stability time, counted in 200 ns ticks.

Software uses a byte-wide bus with address, write data, write enable and combinational read data. The interval is written in three staging bytes and takes effect only when an apply strobe is written to the clear register. A second strobe bit in the same register reloads every filter from the current synchronised inputs. The filtered levels are read back as three bytes and are also driven on a parallel output for downstream change detection.

Top module: `glitch_filter_bank`

## Requirements
- R1: After reset the enable bytes (addresses 0xC, 0xD, 0xE) and the interval staging bytes (0x8, 0x9, 0xA) read 0, and the filtered output is 0.
- R2: A line whose enable bit is 0 shows on the filtered output the raw level three clock cycles after it changes (two synchroniser stages plus one output register).
- R3: On an enabled line with a non-zero active interval N, a raw pulse shorter than (N-1) ticks of 200 ns leaves the filtered level unchanged.
- R4: On an enabled line, a raw level held for N ticks is taken by the filtered output within N ticks plus four cycles. It is not taken earlier than (N-1) ticks after the change. A filtered level only ever changes to the synchronised raw level.
- R5: Writing the staging bytes 0x8 (interval bits 7:0), 0x9 (bits 15:8) and 0xA (bits 19:16 from data bits 3:0; data bits 7:4 are dropped and read back as 0) does not change the active interval. Only writing 1 in bit 0 of the clear register at 0x7 copies the staged value into the active interval, and that write also restarts every line's stability count.
- R6: An active interval of zero makes every line pass through unfiltered, even when its enable bit is set.
- R7: Enable bits form a 24-bit map stored least significant byte first: 0xC holds lines 7:0, 0xD lines 15:8, 0xE lines 23:16. The bits are readable, and each line is filtered or passed through according to its own bit only.
- R8: Writing 1 in bit 1 of the clear register loads every filtered level with the current synchronised level and zeroes all stability counts in the same cycle.
- R9: Reading address 0x0, 0x1 or 0x2 returns filtered lines 7:0, 15:8 or 23:16, with line 0 at bit 0 of address 0x0. Unmapped addresses read 0.
- R10: The filtered level of an enabled line can change only in the cycle after a 200 ns tick or after a filter-clear strobe, unless the active interval is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its frequency is given by parameter CLK_KHZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 24 | Asynchronous raw input lines |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| filt_out | output | 24 | Filtered line levels |

## Verification
The assertions check on every cycle that an unfiltered line copies its synchronised level and that any change of a filtered level lands on the synchronised level. They also check that an enabled line changes only after a tick, a clear strobe or while the interval is zero, and that the active interval holds between apply strobes. The bench's scenarios cover what needs a duration or a register sequence. Those are glitch rejection against the tick count, the earliest and latest commit times, staged intervals that have not yet been applied, byte ordering of the enable map, and the effect of the clear strobe.

// File: rtl/glf_pkg.sv
package glf_pkg;
    localparam int IV_W = 20;
    localparam logic [3:0] OFS_LVL0 = 4'h0;
    localparam logic [3:0] OFS_CLR  = 4'h7;
    localparam logic [3:0] OFS_IV0  = 4'h8;
    localparam logic [3:0] OFS_EN0  = 4'hC;
    localparam int CLR_APPLY_BIT = 0;
    localparam int CLR_FILT_BIT  = 1;

    typedef struct packed {
        logic            filt;
        logic [IV_W-1:0] cnt;
    } line_st_t;
endpackage

// File: rtl/glf_tick.sv
module glf_tick #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/glf_sync.sv
module glf_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/glf_line.sv
module glf_line
    import glf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            en,
    input  logic [IV_W-1:0] iv,
    input  logic            restart,
    input  logic            clr,
    input  logic            din,
    output logic            filt
);
    line_st_t st_d, st_q;
    logic [IV_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (!en || (iv == '0) || clr) begin
            st_d.filt = din;
            st_d.cnt  = '0;
        end else if (restart || (din == st_q.filt)) begin
            st_d.cnt  = '0;
        end else if (tick) begin
            if (cnt_inc >= {1'b0, iv}) begin
                st_d.filt = din;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = cnt_inc[IV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.filt;
endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
    import glf_pkg::*;
#(
    parameter int LINES   = 24,
    parameter int CLK_KHZ = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    output logic [7:0]       bus_rdata,
    output logic [LINES-1:0] filt_out
);
    localparam int NBYTES   = LINES / 8;
    localparam int TICK_RAW = (CLK_KHZ + 2500) / 5000;
    localparam int TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;

    typedef struct packed {
        logic [LINES-1:0] en;
        logic [IV_W-1:0]  stage;
        logic [IV_W-1:0]  act;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [LINES-1:0] sync_q;
    logic             tick;
    logic             clr_wr, apply, clr_f;
    logic [LINES-1:0] en_q;
    logic [IV_W-1:0]  act_q;

    assign clr_wr = bus_we && (bus_addr == OFS_CLR);
    assign apply  = clr_wr && bus_wdata[CLR_APPLY_BIT];
    assign clr_f  = clr_wr && bus_wdata[CLR_FILT_BIT];
    assign en_q   = regs_q.en;
    assign act_q  = regs_q.act;

    glf_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    glf_sync #(.W(LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_q)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        glf_line u_line (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .en(regs_q.en[i]), .iv(regs_q.act),
            .restart(apply), .clr(clr_f),
            .din(sync_q[i]), .filt(filt_out[i])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (bus_addr == OFS_IV0)         regs_d.stage[7:0]   = bus_wdata;
            if (bus_addr == OFS_IV0 + 4'd1)  regs_d.stage[15:8]  = bus_wdata;
            if (bus_addr == OFS_IV0 + 4'd2)  regs_d.stage[19:16] = bus_wdata[3:0];
            for (int k = 0; k < NBYTES; k++) begin
                if (bus_addr == OFS_EN0 + 4'(k)) regs_d.en[k*8 +: 8] = bus_wdata;
            end
        end
        if (apply) regs_d.act = regs_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (bus_addr == OFS_LVL0 + 4'(k)) bus_rdata = filt_out[k*8 +: 8];
            if (bus_addr == OFS_EN0 + 4'(k))  bus_rdata = regs_q.en[k*8 +: 8];
        end
        if (bus_addr == OFS_IV0)        bus_rdata = regs_q.stage[7:0];
        if (bus_addr == OFS_IV0 + 4'd1) bus_rdata = regs_q.stage[15:8];
        if (bus_addr == OFS_IV0 + 4'd2) bus_rdata = {4'h0, regs_q.stage[19:16]};
    end
endmodule

// File: rtl/glf_checker.sv
module glf_checker #(
    parameter int LINES = 24,
    parameter int IV_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] filt,
    input logic [LINES-1:0] sync,
    input logic [LINES-1:0] en,
    input logic             tick,
    input logic             apply,
    input logic             clr_f,
    input logic [IV_W-1:0]  act_iv
);
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((filt ^ $past(sync)) & ~$past(en)) == '0)); // R2

    AST_CHANGE_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((filt ^ $past(filt)) & (filt ^ $past(sync))) == '0)); // R4

    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick || clr_f || (act_iv == '0)) |=> (((filt ^ $past(filt)) & $past(en)) == '0)); // R10

    AST_IV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act_iv)); // R5
endmodule

bind glitch_filter_bank glf_checker #(.LINES(LINES), .IV_W(glf_pkg::IV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .filt(filt_out), .sync(sync_q), .en(en_q),
    .tick(tick), .apply(apply), .clr_f(clr_f), .act_iv(act_q)
);

// File: tb/sim_glitch_filter_bank.sv
module sim_glitch_filter_bank;
    localparam int CLK_PERIOD = 20;

    typedef struct {
        logic [3:0] addr;
        logic [7:0] data;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] raw_in = '0;
    logic [3:0]  drv_addr = '0, mon_addr = '0, bus_addr;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        mon_active = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] filt_out;

    item_t q[$];
    int total = 0, bad = 0;
    bit done = 1'b0;

    assign bus_addr = mon_active ? mon_addr : drv_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    glitch_filter_bank u0 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .filt_out(filt_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        drv_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [7:0] d, input string tag);
        item_t it;
        it.addr = a; it.data = d; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic check_port(input logic [23:0] exp, input string tag);
        total++;
        if (filt_out !== exp) begin
            bad++;
            $display("FAIL %s filt_out actual=%h expected=%h", tag, filt_out, exp);
        end
    endtask

    // monitor: pops expected reads and compares against the bus
    initial begin
        forever begin
            wait (q.size() > 0);
            @(negedge clk);
            mon_active = 1'b1;
            mon_addr   = q[0].addr;
            #1;
            total++;
            if (bus_rdata !== q[0].data) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h",
                         q[0].tag, q[0].addr, bus_rdata, q[0].data);
            end
            mon_active = 1'b0;
            void'(q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        check_port(24'h0, "R1");
        expect_rd(4'hC, 8'h00, "R1 en0");
        expect_rd(4'hE, 8'h00, "R1 en2");
        expect_rd(4'h8, 8'h00, "R1 iv0");
        // R2 / R9 unfiltered pass and byte map
        raw_in = 24'h3C5A81;
        cyc(4);
        expect_rd(4'h0, 8'h81, "R9 byte0");
        expect_rd(4'h1, 8'h5A, "R9 byte1");
        expect_rd(4'h2, 8'h3C, "R2 byte2");
        check_port(24'h3C5A81, "R2 port");
        expect_rd(4'h5, 8'h00, "R9 unmapped");
        // R5 staging, high nibble dropped
        wr(4'h8, 8'h03); wr(4'h9, 8'h00); wr(4'hA, 8'hF0);
        expect_rd(4'hA, 8'h00, "R5 nibble");
        expect_rd(4'h8, 8'h03, "R5 stage");
        wr(4'hC, 8'hFF);
        raw_in = 24'h3C5A00;
        cyc(4);
        expect_rd(4'h0, 8'h00, "R5 not applied");
        // apply interval 3, glitch test
        wr(4'h7, 8'h01);
        raw_in = 24'h3CA5FF;
        cyc(5);
        expect_rd(4'h1, 8'hA5, "R7 unfiltered byte1");
        expect_rd(4'h0, 8'h00, "R3 mid pulse");
        cyc(3);
        raw_in = 24'h3CA500;
        cyc(30);
        expect_rd(4'h0, 8'h00, "R3 glitch rejected");
        // R4 steady level
        raw_in = 24'h3CA5FF;
        cyc(15);
        expect_rd(4'h0, 8'h00, "R4 not early");
        cyc(30);
        expect_rd(4'h0, 8'hFF, "R4 taken");
        // R8 clear strobe
        raw_in = 24'h3CA50F;
        cyc(4);
        wr(4'h7, 8'h02);
        cyc(1);
        expect_rd(4'h0, 8'h0F, "R8 clear");
        // R6 interval zero
        wr(4'h8, 8'h00); wr(4'h7, 8'h01);
        raw_in = 24'h3CA533;
        cyc(4);
        expect_rd(4'h0, 8'h33, "R6 zero bypass");
        // R7 per-line enable in top byte
        wr(4'h8, 8'h05); wr(4'h7, 8'h01); wr(4'hE, 8'h01);
        raw_in = 24'h03A533;
        cyc(5);
        expect_rd(4'h2, 8'h02, "R7 line16 held line17 passed");
        cyc(60);
        expect_rd(4'h2, 8'h03, "R4 line16 taken");
        expect_rd(4'hE, 8'h01, "R7 en2");
        expect_rd(4'hD, 8'h00, "R7 en1");
        expect_rd(4'hC, 8'hFF, "R7 en0");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule